// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block joins two 18-bit tri-state buses, port A and port B, with one data path in each direction. Each path has its own open control, strobe and drive control. It holds its data in one storage element that behaves in two ways. While the open control is high, the element is transparent and its output follows the source bus. While the open control is low, it keeps its value, and a high-to-low transition of the strobe loads the source bus into it.

The two drive controls have opposite polarity. The A-to-B path drives port B while its drive control is high. The B-to-A path drives port A while its drive control is low. If neither path drives a bus, that bus is released to high impedance. Each bus also has a drive-enable output that shows whether the block is currently driving it.

There is no reset. A path holds a known value only after it has been opened once, or after a strobe has loaded it. Nothing arbitrates between the two directions. The system must not enable both paths onto a loop at the same time.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `ab_open` is 1, the A-to-B value follows `port_a`. With `ab_drive` at 1, `port_b` shows that value in the same step.
- R2: While `ab_open` is 0 and `ab_strobe` stays at a steady level (0 or 1), a change on `port_a` does not change the value on `port_b`.
- R3: While `ab_open` is 0, a 1-to-0 transition of `ab_strobe` loads the current `port_a` into the A-to-B storage. A 0-to-1 transition of `ab_strobe` loads nothing.
- R4: `b_drive_en` is 1 exactly when `ab_drive` is 1 (active high). When it is 1, `port_b` carries the A-to-B value. When it is 0, the block releases `port_b`.
- R5: The B-to-A path behaves like R1 to R3 with `ba_open`, `ba_strobe` and source `port_b`. Its drive control is active low: `a_drive_en` is 1 exactly when `ba_drive_n` is 0, and `port_a` then carries the B-to-A value.
- R6: Activity on one path's open or strobe input never changes the value stored in the other path.
- R7: A 1-to-0 transition of `ab_strobe` while `ab_open` is 1 has no effect of its own. The output keeps following `port_a`.
- R8: When `ab_open` goes from 1 to 0, the A-to-B storage keeps the value it was passing at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| port_a | inout | DATA_W (18) | Bus A: source for the A-to-B path, driven by the B-to-A path |
| port_b | inout | DATA_W (18) | Bus B: source for the B-to-A path, driven by the A-to-B path |
| ab_open | input | 1 | A-to-B storage transparent when 1 |
| ab_strobe | input | 1 | A-to-B load strobe, acts on its falling transition |
| ab_drive | input | 1 | Drive port_b when 1 |
| ba_open | input | 1 | B-to-A storage transparent when 1 |
| ba_strobe | input | 1 | B-to-A load strobe, acts on its falling transition |
| ba_drive_n | input | 1 | Drive port_a when 0 |
| a_drive_en | output | 1 | 1 while the block drives port_a |
| b_drive_en | output | 1 | 1 while the block drives port_b |

## Verification
No result passes through a clocked register on the way to a port. A transparent value, a value loaded by a strobe and a change of drive enable all appear at the ports in the same step as the stimulus that causes them. The bench changes its inputs on the falling edge of its own clock and samples on the next rising edge, half a period later, when every result is due. Before any strobe falls, the bench sets up the data on the source bus one step ahead and holds it steady through the edge. The value that should be loaded is therefore never ambiguous.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
   parameter int XCVR_W = 18;

   // polarity of a bus drive control
   typedef enum logic {
      OE_ACT_HIGH = 1'b0,
      OE_ACT_LOW  = 1'b1
   } oe_pol_e;

   // strobe transition that loads the storage while it is closed
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_e;
endpackage

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
// One direction's storage: transparent latch while open, edge-loaded
// register while closed, with a selector remembering which one holds
// the most recent value.
module xcvr_path import xcvr_pkg::*; #(
   parameter int    DATA_W   = XCVR_W,
   parameter edge_e CAP_EDGE = EDGE_FALL
) (
   input  logic [DATA_W-1:0] d_in,
   input  logic              open_i,
   input  logic              strobe_i,
   output logic [DATA_W-1:0] q_o
);
   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] flop_q;
   logic              use_flop;

   if (DATA_W < 1) begin : g_bad_width
      $error("xcvr_path: DATA_W must be at least 1");
   end

   // level-sensitive half: passes data while open, freezes on close
   always_latch begin
      if (open_i) latch_q <= d_in;
   end

   if (CAP_EDGE == EDGE_FALL) begin : g_fall
      always_ff @(negedge strobe_i) flop_q <= d_in;

      // opening hands the output back to the latch; a load edge while
      // closed hands it to the register
      always_ff @(negedge strobe_i or posedge open_i) begin
         if (open_i) use_flop <= 1'b0;
         else        use_flop <= 1'b1;
      end
   end else begin : g_rise
      always_ff @(posedge strobe_i) flop_q <= d_in;

      always_ff @(posedge strobe_i or posedge open_i) begin
         if (open_i) use_flop <= 1'b0;
         else        use_flop <= 1'b1;
      end
   end

   assign q_o = use_flop ? flop_q : latch_q;
endmodule

// File: rtl/xcvr_oe.sv
`timescale 1ns/1ps
// Drive-control decoder with selectable polarity.
module xcvr_oe import xcvr_pkg::*; #(
   parameter oe_pol_e POL = OE_ACT_HIGH
) (
   input  logic oe_i,
   output logic en_o
);
   if (POL == OE_ACT_HIGH) begin : g_hi
      assign en_o = oe_i;
   end else begin : g_lo
      assign en_o = ~oe_i;
   end
endmodule

// File: rtl/dual_path_xcvr.sv
`timescale 1ns/1ps
module dual_path_xcvr import xcvr_pkg::*; #(
   parameter int DATA_W = XCVR_W
) (
   inout  wire  [DATA_W-1:0] port_a,
   inout  wire  [DATA_W-1:0] port_b,
   input  logic              ab_open,
   input  logic              ab_strobe,
   input  logic              ab_drive,
   input  logic              ba_open,
   input  logic              ba_strobe,
   input  logic              ba_drive_n,
   output logic              a_drive_en,
   output logic              b_drive_en
);
   localparam logic [DATA_W-1:0] RELEASED = {DATA_W{1'bz}};

   logic [DATA_W-1:0] ab_val;
   logic [DATA_W-1:0] ba_val;

   if (DATA_W < 1) begin : g_bad_width
      $error("dual_path_xcvr: DATA_W must be at least 1");
   end

   // A to B
   xcvr_path #(.DATA_W(DATA_W), .CAP_EDGE(EDGE_FALL)) u_ab (
      .d_in     (port_a),
      .open_i   (ab_open),
      .strobe_i (ab_strobe),
      .q_o      (ab_val)
   );

   xcvr_oe #(.POL(OE_ACT_HIGH)) u_oe_b (
      .oe_i (ab_drive),
      .en_o (b_drive_en)
   );

   // B to A
   xcvr_path #(.DATA_W(DATA_W), .CAP_EDGE(EDGE_FALL)) u_ba (
      .d_in     (port_b),
      .open_i   (ba_open),
      .strobe_i (ba_strobe),
      .q_o      (ba_val)
   );

   xcvr_oe #(.POL(OE_ACT_LOW)) u_oe_a (
      .oe_i (ba_drive_n),
      .en_o (a_drive_en)
   );

   assign port_b = b_drive_en ? ab_val : RELEASED;
   assign port_a = a_drive_en ? ba_val : RELEASED;
endmodule

// File: rtl/xcvr_chk.sv
`timescale 1ns/1ps
module xcvr_chk #(
   parameter int DATA_W = 18
) (
   input logic [DATA_W-1:0] port_a,
   input logic [DATA_W-1:0] port_b,
   input logic              ab_open,
   input logic              ab_strobe,
   input logic              ab_drive,
   input logic              ba_open,
   input logic              ba_strobe,
   input logic              ba_drive_n,
   input logic [DATA_W-1:0] ab_val,
   input logic [DATA_W-1:0] ba_val
);
   // no reset exists: a path counts as known once it has been opened
   logic ab_primed = 1'b0;
   logic ba_primed = 1'b0;

   always_ff @(posedge ab_open) ab_primed <= 1'b1;
   always_ff @(posedge ba_open) ba_primed <= 1'b1;

   p_follow_r1: assert property (@(posedge ab_strobe) disable iff (!ab_primed)
      ab_open |-> (ab_val == port_a));

   p_bus_b_r4: assert property (@(posedge ab_strobe) disable iff (!ab_primed)
      (ab_drive && ba_drive_n) |-> (port_b == ab_val));

   p_follow_r5: assert property (@(posedge ba_strobe) disable iff (!ba_primed)
      ba_open |-> (ba_val == port_b));

   p_bus_a_r5: assert property (@(posedge ba_strobe) disable iff (!ba_primed)
      (!ba_drive_n && !ab_drive) |-> (port_a == ba_val));
endmodule

bind dual_path_xcvr xcvr_chk #(.DATA_W(DATA_W)) u_chk (
   .port_a     (port_a),
   .port_b     (port_b),
   .ab_open    (ab_open),
   .ab_strobe  (ab_strobe),
   .ab_drive   (ab_drive),
   .ba_open    (ba_open),
   .ba_strobe  (ba_strobe),
   .ba_drive_n (ba_drive_n),
   .ab_val     (ab_val),
   .ba_val     (ba_val)
);

// File: tb/dual_path_xcvr_tb.sv
`timescale 1ns/1ps
module dual_path_xcvr_tb;
   localparam int W = 18;
   localparam int NVEC = 14;

   // {ab_open, ab_strobe, port_a, expected port_b}
   localparam logic [2*W+1:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 18'h12345, 18'h12345},   // R1 transparent
      {1'b1, 1'b0, 18'h2AAAA, 18'h2AAAA},   // R1
      {1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA},   // R8 close
      {1'b0, 1'b0, 18'h15555, 18'h2AAAA},   // R2 strobe steady low
      {1'b0, 1'b1, 18'h15555, 18'h2AAAA},   // R3 rising loads nothing
      {1'b0, 1'b0, 18'h15555, 18'h15555},   // R3 falling loads
      {1'b0, 1'b0, 18'h3FFFF, 18'h15555},   // R2
      {1'b0, 1'b1, 18'h00F0F, 18'h15555},   // R3 rising
      {1'b0, 1'b1, 18'h00001, 18'h15555},   // R2 strobe steady high
      {1'b0, 1'b0, 18'h00001, 18'h00001},   // R3 falling loads
      {1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3},   // R1 reopen
      {1'b1, 1'b1, 18'h0FFFF, 18'h0FFFF},   // R1
      {1'b1, 1'b0, 18'h0ABCD, 18'h0ABCD},   // R7 falling while open
      {1'b1, 1'b0, 18'h01111, 18'h01111}    // R7 still follows
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic tb_rst;
   logic ab_open, ab_strobe, ab_drive, ba_open, ba_strobe, ba_drive_n;
   logic [W-1:0] tb_a, tb_b;
   logic tb_a_en, tb_b_en;
   wire  [W-1:0] port_a, port_b;
   wire  a_drive_en, b_drive_en;

   assign port_a = tb_a_en ? tb_a : {W{1'bz}};
   assign port_b = tb_b_en ? tb_b : {W{1'bz}};

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   dual_path_xcvr #(.DATA_W(W)) u_dut (
      .port_a     (port_a),
      .port_b     (port_b),
      .ab_open    (ab_open),
      .ab_strobe  (ab_strobe),
      .ab_drive   (ab_drive),
      .ba_open    (ba_open),
      .ba_strobe  (ba_strobe),
      .ba_drive_n (ba_drive_n),
      .a_drive_en (a_drive_en),
      .b_drive_en (b_drive_en)
   );

   task automatic chk_v(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_b(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      tb_rst = 1'b1;
      ab_open = 1'b0; ab_strobe = 1'b0; ab_drive = 1'b0;
      ba_open = 1'b0; ba_strobe = 1'b0; ba_drive_n = 1'b1;
      tb_a = '0; tb_b = '0; tb_a_en = 1'b1; tb_b_en = 1'b1;
      repeat (3) @(posedge clk);
      chk_b("R4 reset state, b_drive_en", b_drive_en, 1'b0);
      chk_b("R5 reset state, a_drive_en", a_drive_en, 1'b0);
      @(negedge clk) tb_rst = 1'b0;

      // B driven by the block, A driven by the bench
      @(negedge clk) tb_b_en = 1'b0;
      @(negedge clk) ab_drive = 1'b1;
      @(posedge clk) chk_b("R4 b_drive_en follows ab_drive=1", b_drive_en, 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         ab_open   = VEC[i][2*W+1];
         ab_strobe = VEC[i][2*W];
         tb_a      = VEC[i][2*W-1:W];
         @(posedge clk);
         chk_v($sformatf("R1 R2 R3 R7 R8 vector %0d port_b", i), port_b, VEC[i][W-1:0]);
      end

      // R8: close while passing 01111, then disturb port_a
      @(negedge clk) ab_open = 1'b0;
      @(negedge clk) tb_a = 18'h2F0F0;
      @(posedge clk) chk_v("R8 held at close", port_b, 18'h01111);

      // R4: release B
      @(negedge clk) ab_drive = 1'b0;
      @(posedge clk) chk_b("R4 b_drive_en with ab_drive=0", b_drive_en, 1'b0);

      // B-to-A path
      @(negedge clk) begin tb_b_en = 1'b1; tb_b = 18'h2D2D2; ba_open = 1'b1; end
      @(negedge clk) tb_a_en = 1'b0;
      @(negedge clk) ba_drive_n = 1'b0;
      @(posedge clk);
      chk_b("R5 a_drive_en with ba_drive_n=0", a_drive_en, 1'b1);
      chk_v("R5 transparent port_a", port_a, 18'h2D2D2);
      @(negedge clk) ba_open = 1'b0;
      @(negedge clk) tb_b = 18'h01234;
      @(posedge clk) chk_v("R5 hold port_a", port_a, 18'h2D2D2);
      @(negedge clk) ba_strobe = 1'b1;
      @(posedge clk) chk_v("R5 rising strobe loads nothing", port_a, 18'h2D2D2);
      @(negedge clk) ba_strobe = 1'b0;
      @(posedge clk) chk_v("R5 falling strobe loads", port_a, 18'h01234);

      // R6: A-to-B activity leaves B-to-A storage alone
      @(negedge clk) tb_b = 18'h3ACE5;
      @(negedge clk) ab_open = 1'b1;
      @(negedge clk) ab_open = 1'b0;
      @(negedge clk) ab_strobe = 1'b1;
      @(negedge clk) ab_strobe = 1'b0;
      @(posedge clk) chk_v("R6 B-to-A value after A-to-B activity", port_a, 18'h01234);

      // R6: B-to-A activity leaves A-to-B storage alone
      @(negedge clk) ba_drive_n = 1'b1;
      @(posedge clk) chk_b("R5 a_drive_en with ba_drive_n=1", a_drive_en, 1'b0);
      @(negedge clk) begin tb_a_en = 1'b1; tb_a = 18'h35A5A; ab_open = 1'b1; end
      @(negedge clk) ab_open = 1'b0;
      @(negedge clk) tb_a = 18'h00000;
      @(negedge clk) begin tb_b = 18'h0C0C0; ba_open = 1'b1; end
      @(negedge clk) ba_open = 1'b0;
      @(negedge clk) ba_strobe = 1'b1;
      @(negedge clk) ba_strobe = 1'b0;
      @(negedge clk) tb_b_en = 1'b0;
      @(negedge clk) ab_drive = 1'b1;
      @(posedge clk) chk_v("R6 A-to-B value after B-to-A activity", port_b, 18'h35A5A);

      // B-to-A kept its own last load
      @(negedge clk) ab_drive = 1'b0;
      @(negedge clk) begin tb_b_en = 1'b1; tb_b = 18'h3FFFF; end
      @(negedge clk) tb_a_en = 1'b0;
      @(negedge clk) ba_drive_n = 1'b0;
      @(posedge clk) chk_v("R5 R6 B-to-A holds own load", port_a, 18'h0C0C0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule